// File: doc/BRIEF.md
# MDIO Paged Register Access Bridge

This block sits behind a Clause-22 MDIO management port as a slave. It answers one fixed PHY address and gives access to an internal register space that is larger than the 32 registers Clause 22 can address directly. The internal space is organised as pages of registers that are 8, 16, 32, 48 or 64 bits wide. The serial MDIO framing is decoded elsewhere. This block receives register-write and register-read strobes that already carry the PHY address, the register number and the data.

Software reaches an internal register in four steps:

1. It selects a page through a page register.
2. It fills up to four 16-bit data lanes, with the least significant lane first.
3. It writes an offset into a command register with either the write request bit or the read request bit set.
4. It polls the command register until the request bits read back as zero.

On a read, the result is placed in the data lanes. The internal register file here is a small model with a parameterised access latency. Register width depends on the offset: offset modulo 5 equal to 0, 1, 2, 3 or 4 gives a width of 8, 16, 32, 48 or 64 bits.

Top module: `mdio_page_bridge`

## Requirements
- R1: Only MDIO PHY address 30 is answered, and this address is fixed. A write to any other PHY address changes no state. A read from any other PHY address returns 16'hFFFF. A read also returns 16'hFFFF whenever the read strobe is low.
- R2: MDIO register 0x10 holds the page number in bits 15:8 and the page-enable flag in bit 0. Bits 7:1 read back as zero.
- R3: MDIO register 0x11 holds the offset in bits 15:8, the write request in bit 0 and the read request in bit 1. When a command is accepted, its request bits read back as set, and they read back as zero exactly LATENCY clock edges after the accepting edge. If both request bits are set, a read is performed.
- R4: While the page-enable flag is clear, a command write is ignored. Register 0x11 keeps its value and no internal access takes place.
- R5: A command written while a previous command is still busy is dropped. The offset, the busy timing and the data lanes are not disturbed by it.
- R6: MDIO registers 0x18 to 0x1B are data lanes 0 to 3. They can be written and read back, and lane 0 carries bits 15:0 of the internal value.
- R7: A write stores the lanes, as captured at command acceptance, truncated to the width of the register (8, 16, 32, 48 or 64 bits for offset mod 5 = 0 to 4). An 8-bit register takes only the low byte of lane 0.
- R8: When a read completes, all four lanes are overwritten. They hold the register value zero-extended, so lanes above the register width read zero.
- R9: Pages 0 to NUM_PAGES-1 with offsets 0 to NUM_OFFS-1 are implemented (2 pages and 10 offsets by default). Any other page or offset completes normally: a read returns zero in all lanes and a write is discarded.
- R10: After reset, the page register, the command register, the lanes and every internal register are zero. MDIO registers other than 0x10, 0x11 and 0x18 to 0x1B read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mdWrEn | input | 1 | Decoded MDIO register-write strobe, one cycle |
| mdRdEn | input | 1 | Decoded MDIO register-read strobe |
| mdPhyAddr | input | 5 | PHY address of the MDIO access |
| mdRegAddr | input | 5 | Register number of the MDIO access |
| mdWrData | input | 16 | Write data |
| mdRdData | output | 16 | Read data, combinational while mdRdEn is high |

## Verification
The assertions assume a few things about the inputs: write strobes last one cycle, the register number is stable while a strobe is high, and software does not write a data lane in the same cycle that a read completes. The stimulus keeps to these assumptions. Every access is driven for exactly one clock on the falling edge. When the bench polls busy, it uses reads only, and it writes lanes only once the request bits have cleared. The one exception is a deliberate command issued during the busy window, which is used to show that such a command is dropped. The sweep covers every page and offset combination up to one beyond the implemented range, so every register width and every unimplemented address is exercised.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
  localparam int LANE_W = 16;
  localparam int LANES = 4;
  localparam int VAL_W = LANE_W * LANES;
  localparam logic [4:0] BRIDGE_PHY = 5'd30;
  localparam logic [4:0] REG_PAGE = 5'h10;
  localparam logic [4:0] REG_CMD = 5'h11;
  localparam logic [4:0] REG_LANE0 = 5'h18;

  typedef struct packed {
    logic pageWr;
    logic cmdAccept;
    logic [LANES-1:0] laneWr;
    logic exec;
    logic busy;
  } bridge_strb_t;

  // Width of an internal register as a function of its offset.
  function automatic logic [VAL_W-1:0] widthMask(input logic [7:0] off);
    logic [7:0] cls;
    cls = off % 8'd5;
    case (cls)
      8'd0: widthMask = 64'h0000_0000_0000_00FF;
      8'd1: widthMask = 64'h0000_0000_0000_FFFF;
      8'd2: widthMask = 64'h0000_0000_FFFF_FFFF;
      8'd3: widthMask = 64'h0000_FFFF_FFFF_FFFF;
      default: widthMask = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/mdio_bridge_ctrl.sv
module mdio_bridge_ctrl
  import mdio_bridge_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic mdWrEn,
  input  logic [4:0] mdPhyAddr,
  input  logic [4:0] mdRegAddr,
  input  logic [1:0] reqBits,
  input  logic pageEn,
  output bridge_strb_t strb
);
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic busyQ;
  logic [CNT_W-1:0] cntQ;
  logic phyHit;
  logic cmdReq;

  assign phyHit = mdWrEn && (mdPhyAddr == BRIDGE_PHY);
  assign cmdReq = phyHit && (mdRegAddr == REG_CMD) && (reqBits != 2'b00);

  assign strb.pageWr = phyHit && (mdRegAddr == REG_PAGE);
  assign strb.cmdAccept = cmdReq && pageEn && !busyQ;
  assign strb.exec = busyQ && (cntQ == '0);
  assign strb.busy = busyQ;

  for (genvar i = 0; i < LANES; i++) begin : gLaneDec
    assign strb.laneWr[i] = phyHit && (mdRegAddr == REG_LANE0 + 5'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ <= '0;
    end else if (strb.cmdAccept) begin
      busyQ <= 1'b1;
      cntQ <= CNT_W'(LATENCY - 1);
    end else if (busyQ) begin
      if (cntQ == '0) busyQ <= 1'b0;
      else cntQ <= cntQ - CNT_W'(1);
    end
  end

  AST_EXEC_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strb.exec |=> !busyQ); // R3

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && cntQ != '0) |=> (busyQ && cntQ == $past(cntQ) - CNT_W'(1))); // R5

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!pageEn && !busyQ) |=> !busyQ); // R4
endmodule

// File: rtl/mdio_bridge_dp.sv
module mdio_bridge_dp
  import mdio_bridge_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  bridge_strb_t strb,
  input  logic mdRdEn,
  input  logic [4:0] mdPhyAddr,
  input  logic [4:0] mdRegAddr,
  input  logic [15:0] mdWrData,
  input  logic [VAL_W-1:0] rdValue,
  output logic pageEn,
  output logic [7:0] accPage,
  output logic [7:0] accOff,
  output logic accIsWrite,
  output logic [VAL_W-1:0] wrHold,
  output logic [15:0] mdRdData
);
  logic [7:0] pageNumQ;
  logic pageEnQ;
  logic [7:0] cmdOffQ;
  logic [1:0] cmdBitsQ;
  logic [7:0] pageHoldQ;
  logic [VAL_W-1:0] wrHoldQ;
  logic [LANE_W-1:0] laneQ [LANES];
  logic [VAL_W-1:0] laneCat;

  always_comb begin
    for (int i = 0; i < LANES; i++) laneCat[i*LANE_W +: LANE_W] = laneQ[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageNumQ <= '0;
      pageEnQ <= 1'b0;
    end else if (strb.pageWr) begin
      pageNumQ <= mdWrData[15:8];
      pageEnQ <= mdWrData[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdOffQ <= '0;
      cmdBitsQ <= '0;
      pageHoldQ <= '0;
      wrHoldQ <= '0;
    end else if (strb.cmdAccept) begin
      cmdOffQ <= mdWrData[15:8];
      cmdBitsQ <= mdWrData[1:0];
      pageHoldQ <= pageNumQ;
      wrHoldQ <= laneCat;
    end else if (strb.exec) begin
      cmdBitsQ <= 2'b00;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (!rstN) laneQ[i] <= '0;
      else if (strb.exec && !accIsWrite) laneQ[i] <= rdValue[i*LANE_W +: LANE_W];
      else if (strb.laneWr[i]) laneQ[i] <= mdWrData;
    end
  end

  assign pageEn = pageEnQ;
  assign accPage = pageHoldQ;
  assign accOff = cmdOffQ;
  assign accIsWrite = !cmdBitsQ[1];
  assign wrHold = wrHoldQ;

  always_comb begin
    mdRdData = 16'hFFFF;
    if (mdRdEn && mdPhyAddr == BRIDGE_PHY) begin
      case (mdRegAddr)
        REG_PAGE: mdRdData = {pageNumQ, 7'b0, pageEnQ};
        REG_CMD: mdRdData = {cmdOffQ, 6'b0, cmdBitsQ};
        5'h18: mdRdData = laneQ[0];
        5'h19: mdRdData = laneQ[1];
        5'h1A: mdRdData = laneQ[2];
        5'h1B: mdRdData = laneQ[3];
        default: mdRdData = 16'h0000;
      endcase
    end
  end

  AST_CMD_TRACKS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBitsQ != 2'b00) == strb.busy); // R3

  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.laneWr)); // R6
endmodule

// File: rtl/mdio_bridge_regfile.sv
module mdio_bridge_regfile
  import mdio_bridge_pkg::*;
#(
  parameter int NUM_PAGES = 2,
  parameter int NUM_OFFS = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic exec,
  input  logic isWrite,
  input  logic [7:0] page,
  input  logic [7:0] off,
  input  logic [VAL_W-1:0] wrData,
  output logic [VAL_W-1:0] rdData
);
  localparam int ENTRIES = NUM_PAGES * NUM_OFFS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic implemented;
  logic [IDX_W-1:0] idx;
  logic [VAL_W-1:0] entryVal [ENTRIES];

  assign implemented = (int'(page) < NUM_PAGES) && (int'(off) < NUM_OFFS);
  assign idx = IDX_W'(int'(page) * NUM_OFFS + int'(off));

  for (genvar e = 0; e < ENTRIES; e++) begin : gEntry
    logic [VAL_W-1:0] valQ;
    always_ff @(posedge clk) begin
      if (!rstN) valQ <= '0;
      else if (exec && isWrite && implemented && idx == IDX_W'(e))
        valQ <= wrData & widthMask(off);
    end
    assign entryVal[e] = valQ;
  end

  always_comb begin
    rdData = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (implemented && idx == IDX_W'(e)) rdData = entryVal[e];
  end

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !implemented |-> rdData == '0); // R9
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int LATENCY = 4,
  parameter int NUM_PAGES = 2,
  parameter int NUM_OFFS = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic mdWrEn,
  input  logic mdRdEn,
  input  logic [4:0] mdPhyAddr,
  input  logic [4:0] mdRegAddr,
  input  logic [15:0] mdWrData,
  output logic [15:0] mdRdData
);
  bridge_strb_t strb;
  logic pageEn;
  logic [7:0] accPage;
  logic [7:0] accOff;
  logic accIsWrite;
  logic [VAL_W-1:0] wrHold;
  logic [VAL_W-1:0] rdValue;

  mdio_bridge_ctrl #(.LATENCY(LATENCY)) uCtrl (
    .clk(clk), .rstN(rstN), .mdWrEn(mdWrEn), .mdPhyAddr(mdPhyAddr),
    .mdRegAddr(mdRegAddr), .reqBits(mdWrData[1:0]), .pageEn(pageEn), .strb(strb)
  );

  mdio_bridge_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .mdRdEn(mdRdEn), .mdPhyAddr(mdPhyAddr),
    .mdRegAddr(mdRegAddr), .mdWrData(mdWrData), .rdValue(rdValue), .pageEn(pageEn),
    .accPage(accPage), .accOff(accOff), .accIsWrite(accIsWrite), .wrHold(wrHold),
    .mdRdData(mdRdData)
  );

  mdio_bridge_regfile #(.NUM_PAGES(NUM_PAGES), .NUM_OFFS(NUM_OFFS)) uRegs (
    .clk(clk), .rstN(rstN), .exec(strb.exec), .isWrite(accIsWrite), .page(accPage),
    .off(accOff), .wrData(wrHold), .rdData(rdValue)
  );

  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (mdWrEn && mdPhyAddr != BRIDGE_PHY) |->
      (!strb.pageWr && !strb.cmdAccept && strb.laneWr == '0)); // R1
endmodule

// File: tb/tb_mdio_page_bridge.sv
module tb_mdio_page_bridge;
  localparam int LAT = 4;
  localparam int NP = 2;
  localparam int NO = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mdWrEn = 1'b0;
  logic mdRdEn = 1'b0;
  logic [4:0] mdPhyAddr = '0;
  logic [4:0] mdRegAddr = '0;
  logic [15:0] mdWrData = '0;
  logic [15:0] mdRdData;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  mdio_page_bridge #(.LATENCY(LAT), .NUM_PAGES(NP), .NUM_OFFS(NO)) dut (
    .clk(clk), .rstN(rstN), .mdWrEn(mdWrEn), .mdRdEn(mdRdEn), .mdPhyAddr(mdPhyAddr),
    .mdRegAddr(mdRegAddr), .mdWrData(mdWrData), .mdRdData(mdRdData)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic mdWrite(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    mdWrEn = 1'b1; mdPhyAddr = phy; mdRegAddr = ra; mdWrData = d;
    @(posedge clk);
    @(negedge clk);
    mdWrEn = 1'b0;
  endtask

  task automatic mdRead(input logic [4:0] phy, input logic [4:0] ra, output logic [15:0] d);
    mdRdEn = 1'b1; mdPhyAddr = phy; mdRegAddr = ra;
    #1;
    d = mdRdData;
    mdRdEn = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [4:0] ra, input logic [15:0] exp);
    logic [15:0] v;
    mdRead(5'd30, ra, v);
    check(req, v, exp);
  endtask

  task automatic loadLanes(input logic [63:0] v);
    for (int l = 0; l < 4; l++) mdWrite(5'd30, 5'(5'h18 + l), v[16*l +: 16]);
  endtask

  task automatic waitDone();
    repeat (LAT + 1) @(negedge clk);
  endtask

  function automatic logic [63:0] pat(input int p, input int o);
    return 64'h9E37_79B9_7F4A_7C15 ^ (64'(p) << 40) ^ (64'(o) * 64'h0001_0003_0005_0007);
  endfunction

  function automatic logic [63:0] maskOf(input int o);
    case (o % 5)
      0: return 64'hFF;
      1: return 64'hFFFF;
      2: return 64'hFFFF_FFFF;
      3: return 64'hFFFF_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [63:0] expV;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    expectReg("R10 page reset", 5'h10, 16'h0000);
    expectReg("R10 cmd reset", 5'h11, 16'h0000);
    for (int l = 0; l < 4; l++) expectReg("R10 lane reset", 5'(5'h18 + l), 16'h0000);
    expectReg("R10 unmapped reg", 5'h05, 16'h0000);

    // R2 page register fields
    mdWrite(5'd30, 5'h10, 16'hABFF);
    expectReg("R2 page readback", 5'h10, 16'hAB01);

    // R6 lane readback
    loadLanes(64'h4444_3333_2222_1111);
    for (int l = 0; l < 4; l++)
      expectReg("R6 lane readback", 5'(5'h18 + l), 16'(16'h1111 * (l + 1)));

    // Sweep: write then read every page/offset, including unimplemented ones
    for (int p = 0; p <= NP; p++) begin
      for (int o = 0; o < NO + 2; o++) begin
        mdWrite(5'd30, 5'h10, {8'(p), 8'h01});
        loadLanes(pat(p, o));
        mdWrite(5'd30, 5'h11, {8'(o), 8'h01});
        for (int j = 0; j <= LAT; j++) begin
          mdRead(5'd30, 5'h11, v);
          check("R3 busy timing", v, (j < LAT) ? {8'(o), 8'h01} : {8'(o), 8'h00});
          @(negedge clk);
        end
        loadLanes(64'hFFFF_FFFF_FFFF_FFFF);
        mdWrite(5'd30, 5'h11, {8'(o), 8'h02});
        waitDone();
        expV = (p < NP && o < NO) ? (pat(p, o) & maskOf(o)) : 64'h0;
        for (int l = 0; l < 4; l++)
          expectReg((p < NP && o < NO) ? "R7 R8 write/read value" : "R9 unimplemented",
                    5'(5'h18 + l), expV[16*l +: 16]);
      end
    end

    // R5 command during busy is dropped
    mdWrite(5'd30, 5'h10, 16'h0001);
    loadLanes(64'h0000_0000_5A5A_C3C3);
    mdWrite(5'd30, 5'h11, 16'h0101);
    mdWrite(5'd30, 5'h11, 16'h0202);
    waitDone();
    expectReg("R5 offset kept", 5'h11, 16'h0100);
    expectReg("R5 lane0 kept", 5'h18, 16'hC3C3);
    expectReg("R5 lane1 kept", 5'h19, 16'h5A5A);

    // R4 page disabled: command ignored
    mdWrite(5'd30, 5'h10, 16'h0000);
    loadLanes(64'h1234_5678_9ABC_DEF0);
    mdWrite(5'd30, 5'h11, 16'h0301);
    expectReg("R4 cmd unchanged", 5'h11, 16'h0100);
    waitDone();
    mdWrite(5'd30, 5'h10, 16'h0001);
    mdWrite(5'd30, 5'h11, 16'h0302);
    waitDone();
    expV = pat(0, 3) & maskOf(3);
    expectReg("R4 reg unchanged lane0", 5'h18, expV[15:0]);
    expectReg("R4 reg unchanged lane2", 5'h1A, expV[47:32]);

    // R3 both request bits: read wins, no write
    loadLanes(64'h0BAD_F00D_0BAD_F00D);
    mdWrite(5'd30, 5'h11, 16'h0403);
    waitDone();
    expV = pat(0, 4);
    expectReg("R3 both bits read lane0", 5'h18, expV[15:0]);
    expectReg("R3 both bits read lane3", 5'h1B, expV[63:48]);

    // R1 foreign PHY addresses
    mdWrite(5'd3, 5'h10, 16'h7700);
    mdWrite(5'd31, 5'h18, 16'hBEEF);
    mdWrite(5'd0, 5'h11, 16'h0202);
    mdRead(5'd29, 5'h10, v);
    check("R1 foreign read", v, 16'hFFFF);
    mdRdEn = 1'b0; mdPhyAddr = 5'd30; mdRegAddr = 5'h10;
    #1;
    check("R1 no strobe read", mdRdData, 16'hFFFF);
    expectReg("R1 page unchanged", 5'h10, 16'h0001);
    expectReg("R1 lane unchanged", 5'h18, expV[15:0]);
    expectReg("R1 cmd idle", 5'h11, 16'h0400);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule